// File: doc/BRIEF.md
# Component Video Line Stream Generator

This block produces the multiplexed 10-bit word stream of a 4:2:2 component video interface, one word per enabled clock. It keeps its own position within the line and the line number within the frame. It frames every line with two four-word timing codes. The end-of-active-video code opens the line and the start-of-active-video code sits just before the picture samples. Each code carries the field, vertical-blanking and horizontal flags together with four protection bits.

During horizontal blanking, and across the whole picture region of vertically blanked lines, the block emits the blanking fill. On picture lines it takes chroma and luma samples from an upstream source through a valid/ready port, clips any reserved value and places it in the stream. The line standard (625 or 525 lines) is picked by a select pin and is latched once per frame.

The sample port is paced by the video timing and cannot be stalled. `smp_ready` is asserted, whatever `smp_valid` is, on every enabled cycle that falls in the picture region of an unblanked line. A transfer happens when both signals are high in such a cycle. The source must hold `smp_data` until a transfer takes it, and must not make `smp_valid` depend on `smp_ready`. If `smp_valid` is low when `smp_ready` is high, the slot is filled with the blanking level of that component and no sample is consumed.

`WORDS_PER_LINE` must be a multiple of 4. `ACTIVE_SAMPLES` must be even. `WORDS_PER_LINE` must be at least 2*`ACTIVE_SAMPLES` + 8.

Top module: `cvid_line_gen`

## Requirements
- R1: While `rst_n` is low, `vid_word` is 200h, `line_num` is 0, `field_id` is 0 and `smp_ready` is 0. The first word after reset is position 0 of line 1.
- R2: `vid_word`, `line_num` and `field_id` change only on a rising edge with `word_en` high. Each such edge emits the word for the current position on the following cycle and then advances the position by one.
- R3: A line has `WORDS_PER_LINE` positions. Positions 0..3 hold the end-of-active-video code. The 4 positions before the last 2*`ACTIVE_SAMPLES` hold the start-of-active-video code. The last 2*`ACTIVE_SAMPLES` positions are the picture region. Lines count 1..625 or 1..525 and then wrap to 1. `line_num` gives the line of the word on `vid_word`.
- R4: A timing code is the word sequence 3FFh, 000h, 000h, XY. In XY, bit 9 is 1, bit 8 is F, bit 7 is V and bit 6 is H. Bits 5..2 hold V^H, F^H, F^V and F^V^H, and bits 1..0 are 0. H is 1 in the end-of-active-video code and 0 in the start-of-active-video code.
- R5: In 625-line mode, V is 1 on lines 624..625, lines 1..22 and lines 311..335, and 0 on all other lines.
- R6: In 525-line mode, V is 1 on lines 1..19 and lines 264..282, and 0 on all other lines.
- R7: In 625-line mode, F is 0 on lines 1..312 and 1 on lines 313..625. In 525-line mode, F is 0 on lines 4..265 and 1 elsewhere. `field_id` shows the F of the word's line.
- R8: A blanking-fill word is 200h at an even position and 040h at an odd position. Fill words occupy every position between the two codes and the whole picture region of lines with V=1.
- R9: `smp_ready` is high exactly when `word_en` is high and the position is in the picture region of a line with V=0. A transferred sample becomes the emitted word, in the order CB, Y, CR, Y counted from the start of the picture region.
- R10: In a cycle with `smp_ready` high and `smp_valid` low, the emitted word is the fill value of R8 for that position.
- R11: A transferred sample whose bits 9..2 are all 1 is emitted as 3FBh. One whose bits 9..2 are all 0 is emitted as 004h. All other samples pass unchanged.
- R12: `std_525` (1 selects 525 lines, 0 selects 625) is sampled on the enabled word at position 0 of line 1. It governs the flags and the wrap point for that whole frame. Changes at any other time have no effect until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_en | input | 1 | Word-rate enable, one word per high cycle |
| std_525 | input | 1 | Line standard select: 1 = 525 lines, 0 = 625 lines |
| smp_valid | input | 1 | Sample source has a sample on `smp_data` |
| smp_ready | output | 1 | Generator takes a sample this cycle if valid |
| smp_data | input | 10 | Component sample, CB/Y/CR/Y order |
| vid_word | output | 10 | Multiplexed interface word |
| line_num | output | LINE_W (10) | Line number of the word on `vid_word` |
| field_id | output | 1 | Field flag F of that line |

## Verification
`smp_ready` is combinational, so the bench checks it 1 ns after it drives the inputs, in the same cycle. `vid_word`, `line_num` and `field_id` are due one cycle after each enabled rising edge. The bench compares them at the falling edge that follows, against a word it computed from its own position and line model when it drove that enable. On cycles with `word_en` low, the bench checks at the next falling edge that all three outputs hold their previous expected values. Whole 625- and 525-line frames run with random enables, random valid gaps and reserved sample values. The select is flipped mid-frame to show that it waits for the frame start.

// File: rtl/cvid_pkg.sv
package cvid_pkg;

  typedef enum logic [1:0] {
    SEG_EAV  = 2'd0,
    SEG_HBLK = 2'd1,
    SEG_SAV  = 2'd2,
    SEG_ACT  = 2'd3
  } seg_e;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } flags_t;

  // Reserved and fill word values
  localparam logic [9:0] W_PRE_HI  = 10'h3FF;
  localparam logic [9:0] W_PRE_LO  = 10'h000;
  localparam logic [9:0] W_FILL_C  = 10'h200;
  localparam logic [9:0] W_FILL_Y  = 10'h040;
  localparam logic [9:0] W_CLIP_LO = 10'h004;
  localparam logic [9:0] W_CLIP_HI = 10'h3FB;

  // Frame lengths and flag boundaries of the two line standards
  localparam int L625_LAST      = 625;
  localparam int L625_V1_END    = 23;
  localparam int L625_V2_START  = 311;
  localparam int L625_V2_END    = 336;
  localparam int L625_V1_START  = 624;
  localparam int L625_F2_START  = 313;

  localparam int L525_LAST      = 525;
  localparam int L525_V1_END    = 20;
  localparam int L525_V2_START  = 264;
  localparam int L525_V2_END    = 283;
  localparam int L525_F1_START  = 4;
  localparam int L525_F2_START  = 266;

  // Fourth word of a timing code with its protection bits
  function automatic logic [9:0] code_word(flags_t fl);
    logic p3, p2, p1, p0;
    p3 = fl.v ^ fl.h;
    p2 = fl.f ^ fl.h;
    p1 = fl.f ^ fl.v;
    p0 = fl.f ^ fl.v ^ fl.h;
    return {1'b1, fl.f, fl.v, fl.h, p3, p2, p1, p0, 2'b00};
  endfunction

  // Map reserved sample codes to the nearest legal value
  function automatic logic [9:0] clip_sample(logic [9:0] s);
    if (s[9:2] == 8'hFF) return W_CLIP_HI;
    if (s[9:2] == 8'h00) return W_CLIP_LO;
    return s;
  endfunction

endpackage

// File: rtl/cvid_pos_ctr.sv
module cvid_pos_ctr
  import cvid_pkg::*;
#(
  parameter int WORDS_PER_LINE = 64,
  parameter int ACTIVE_SAMPLES = 16,
  parameter int LINE_W         = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_en,
  input  logic              std_525,
  output logic [LINE_W-1:0] line,
  output logic [1:0]        sub_idx,
  output logic              std_eff,
  output seg_e              seg
);
  localparam int POS_W     = $clog2(WORDS_PER_LINE);
  localparam int ACT_WORDS = 2 * ACTIVE_SAMPLES;
  localparam logic [POS_W-1:0] P_LAST = POS_W'(WORDS_PER_LINE - 1);
  localparam logic [POS_W-1:0] P_HBLK = POS_W'(4);
  localparam logic [POS_W-1:0] P_SAV  = POS_W'(WORDS_PER_LINE - ACT_WORDS - 4);
  localparam logic [POS_W-1:0] P_ACT  = POS_W'(WORDS_PER_LINE - ACT_WORDS);
  localparam logic [LINE_W-1:0] LN_ONE  = LINE_W'(1);
  localparam logic [LINE_W-1:0] LN_625  = LINE_W'(L625_LAST);
  localparam logic [LINE_W-1:0] LN_525  = LINE_W'(L525_LAST);

  logic [POS_W-1:0]  pos_q;
  logic [LINE_W-1:0] line_q;
  logic              std_q;
  logic              frame_start;
  logic [LINE_W-1:0] line_last;

  assign frame_start = (line_q == LN_ONE) && (pos_q == '0);
  assign std_eff     = frame_start ? std_525 : std_q;
  assign line_last   = std_eff ? LN_525 : LN_625;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      line_q <= LN_ONE;
      std_q  <= 1'b0;
    end else if (word_en) begin
      if (frame_start) std_q <= std_525;
      if (pos_q == P_LAST) begin
        pos_q  <= '0;
        line_q <= (line_q == line_last) ? LN_ONE : line_q + LN_ONE;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (pos_q < P_HBLK)     seg = SEG_EAV;
    else if (pos_q < P_SAV) seg = SEG_HBLK;
    else if (pos_q < P_ACT) seg = SEG_SAV;
    else                    seg = SEG_ACT;
  end

  assign line    = line_q;
  assign sub_idx = pos_q[1:0];

endmodule

// File: rtl/cvid_flag_dec.sv
module cvid_flag_dec
  import cvid_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input  logic [LINE_W-1:0] line,
  input  logic              std_525,
  output logic              f_flag,
  output logic              v_flag
);
  logic v625, v525, f625, f525;

  always_comb begin
    v625 = (line >= LINE_W'(L625_V1_START)) || (line < LINE_W'(L625_V1_END)) ||
           ((line >= LINE_W'(L625_V2_START)) && (line < LINE_W'(L625_V2_END)));
    v525 = (line < LINE_W'(L525_V1_END)) ||
           ((line >= LINE_W'(L525_V2_START)) && (line < LINE_W'(L525_V2_END)));
    f625 = (line >= LINE_W'(L625_F2_START));
    f525 = (line >= LINE_W'(L525_F2_START)) || (line < LINE_W'(L525_F1_START));
  end

  assign f_flag = std_525 ? f525 : f625;
  assign v_flag = std_525 ? v525 : v625;

endmodule

// File: rtl/cvid_word_mux.sv
module cvid_word_mux
  import cvid_pkg::*;
(
  input  seg_e       seg,
  input  logic [1:0] sub_idx,
  input  logic       f_flag,
  input  logic       v_flag,
  input  logic       smp_valid,
  input  logic [9:0] smp_data,
  output logic       in_picture,
  output logic [9:0] word_next
);
  logic [9:0] fill;
  flags_t     fl;

  assign fill       = sub_idx[0] ? W_FILL_Y : W_FILL_C;
  assign in_picture = (seg == SEG_ACT) && !v_flag;

  always_comb begin
    fl.f = f_flag;
    fl.v = v_flag;
    fl.h = (seg == SEG_EAV);
    word_next = fill;
    unique case (seg)
      SEG_EAV, SEG_SAV: begin
        unique case (sub_idx)
          2'd0:    word_next = W_PRE_HI;
          2'd3:    word_next = code_word(fl);
          default: word_next = W_PRE_LO;
        endcase
      end
      SEG_ACT: begin
        if (in_picture && smp_valid) word_next = clip_sample(smp_data);
      end
      default: word_next = fill;
    endcase
  end

endmodule

// File: rtl/cvid_line_gen.sv
module cvid_line_gen
  import cvid_pkg::*;
#(
  parameter int WORDS_PER_LINE = 64,
  parameter int ACTIVE_SAMPLES = 16,
  parameter int LINE_W         = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_en,
  input  logic              std_525,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [9:0]        smp_data,
  output logic [9:0]        vid_word,
  output logic [LINE_W-1:0] line_num,
  output logic              field_id
);
  logic [LINE_W-1:0] line;
  logic [1:0]        sub_idx;
  logic              std_eff;
  seg_e              seg;
  logic              f_flag, v_flag;
  logic              in_picture;
  logic [9:0]        word_next;

  cvid_pos_ctr #(
    .WORDS_PER_LINE(WORDS_PER_LINE),
    .ACTIVE_SAMPLES(ACTIVE_SAMPLES),
    .LINE_W        (LINE_W)
  ) u_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .word_en (word_en),
    .std_525 (std_525),
    .line    (line),
    .sub_idx (sub_idx),
    .std_eff (std_eff),
    .seg     (seg)
  );

  cvid_flag_dec #(.LINE_W(LINE_W)) u_flags (
    .line    (line),
    .std_525 (std_eff),
    .f_flag  (f_flag),
    .v_flag  (v_flag)
  );

  cvid_word_mux u_mux (
    .seg        (seg),
    .sub_idx    (sub_idx),
    .f_flag     (f_flag),
    .v_flag     (v_flag),
    .smp_valid  (smp_valid),
    .smp_data   (smp_data),
    .in_picture (in_picture),
    .word_next  (word_next)
  );

  assign smp_ready = word_en && in_picture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_word <= W_FILL_C;
      line_num <= '0;
      field_id <= 1'b0;
    end else if (word_en) begin
      vid_word <= word_next;
      line_num <= line;
      field_id <= f_flag;
    end
  end

endmodule

// File: rtl/cvid_line_gen_chk.sv
module cvid_line_gen_chk #(
  parameter int LINE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_en,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic [9:0]        vid_word,
  input logic [LINE_W-1:0] line_num,
  input logic              field_id
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !word_en |=> ($stable(vid_word) && $stable(line_num) && $stable(field_id)))
    else $error("p_hold_r2");

  p_ready_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |-> word_en)
    else $error("p_ready_gate_r9");

  p_clip_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_ready && smp_valid) |=> (vid_word[9:2] != 8'hFF && vid_word[9:2] != 8'h00))
    else $error("p_clip_r11");

  p_line_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_num) |-> (line_num == $past(line_num) + LINE_W'(1) || line_num == LINE_W'(1)))
    else $error("p_line_step_r3");

  p_line_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    line_num <= LINE_W'(625))
    else $error("p_line_max_r3");

  p_field_at_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field_id) |-> !$stable(line_num))
    else $error("p_field_at_line_r7");

endmodule

bind cvid_line_gen cvid_line_gen_chk #(.LINE_W(LINE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .word_en   (word_en),
  .smp_valid (smp_valid),
  .smp_ready (smp_ready),
  .vid_word  (vid_word),
  .line_num  (line_num),
  .field_id  (field_id)
);

// File: tb/tb_cvid_line_gen.sv
`timescale 1ns/1ps
module tb_cvid_line_gen;
  localparam int T  = 64;
  localparam int A  = 16;
  localparam int AW = 2 * A;
  localparam int SAVS = T - AW - 4;
  localparam int ACTS = T - AW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       word_en = 1'b0;
  logic       std_525 = 1'b0;
  logic       smp_valid = 1'b0;
  logic       smp_ready;
  logic [9:0] smp_data = 10'h000;
  logic [9:0] vid_word;
  logic [9:0] line_num;
  logic       field_id;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // model state
  int m_line = 1;
  int m_pos = 0;
  bit m_std = 0;
  logic [9:0] e_word = 10'h200;
  int e_line = 0;
  bit e_field = 0;
  string e_tag = "R1";

  always #2 clk = ~clk;

  cvid_line_gen #(.WORDS_PER_LINE(T), .ACTIVE_SAMPLES(A), .LINE_W(10)) dut (
    .clk(clk), .rst_n(rst_n), .word_en(word_en), .std_525(std_525),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .vid_word(vid_word), .line_num(line_num), .field_id(field_id)
  );

  function automatic bit ref_v(int ln, bit s525);
    if (s525) return (ln <= 19) || (ln >= 264 && ln <= 282);
    return (ln >= 624) || (ln <= 22) || (ln >= 311 && ln <= 335);
  endfunction

  function automatic bit ref_f(int ln, bit s525);
    if (s525) return !(ln >= 4 && ln <= 265);
    return ln >= 313;
  endfunction

  function automatic logic [9:0] ref_fill(int pos);
    return (pos % 2 == 0) ? 10'h200 : 10'h040;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (line %0d pos %0d)", tag, act, exp, m_line, m_pos);
    end
  endtask

  // One cycle: drive inputs, check ready, compute expected, clock, check outputs
  task automatic step(bit en, bit vld, logic [9:0] d, bit s);
    bit seff, f, v, h, pict, ready_exp;
    int idx;
    logic [9:0] w;
    string tag;
    word_en = en; smp_valid = vld; smp_data = d; std_525 = s;
    #1;
    seff = (m_line == 1 && m_pos == 0) ? s : m_std;
    f = ref_f(m_line, seff);
    v = ref_v(m_line, seff);
    pict = (m_pos >= ACTS) && !v;
    ready_exp = en && pict;
    check(smp_ready == ready_exp, "R9 smp_ready", smp_ready, ready_exp);
    if (en) begin
      idx = m_pos % 4;
      if (m_pos < 4 || (m_pos >= SAVS && m_pos < ACTS)) begin
        h = (m_pos < 4);
        if (idx == 0) w = 10'h3FF;
        else if (idx == 3) w = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
        else w = 10'h000;
        tag = seff ? "R4 R6 R7 code" : "R4 R5 R7 code";
      end else if (pict) begin
        if (!vld) begin
          w = ref_fill(m_pos); tag = "R10 underrun";
        end else if (d[9:2] == 8'hFF) begin
          w = 10'h3FB; tag = "R11 clip high";
        end else if (d[9:2] == 8'h00) begin
          w = 10'h004; tag = "R11 clip low";
        end else begin
          w = d; tag = "R9 sample";
        end
      end else begin
        w = ref_fill(m_pos);
        tag = (m_pos >= ACTS) ? (seff ? "R8 R6 vblank fill" : "R8 R5 vblank fill") : "R8 hblank fill";
      end
      e_word = w; e_line = m_line; e_field = f; e_tag = tag;
      if (m_line == 1 && m_pos == 0) m_std = s;
      if (m_pos == T - 1) begin
        m_pos = 0;
        m_line = (m_line == (seff ? 525 : 625)) ? 1 : m_line + 1;
      end else m_pos++;
    end else e_tag = "R2 hold";
    @(negedge clk);
    check(vid_word == e_word, e_tag, vid_word, e_word);
    check(line_num == 10'(e_line), "R3 R12 line_num", line_num, e_line);
    check(field_id == e_field, "R7 field_id", field_id, e_field);
  endtask

  function automatic logic [9:0] pick_data();
    int r;
    r = $urandom % 10;
    if (r == 0) return 10'h000 + 10'($urandom % 4);
    if (r == 1) return 10'h3FC + 10'($urandom % 4);
    if (r == 2) return ($urandom % 2) ? 10'h004 : 10'h3FB;
    return 10'($urandom);
  endfunction

  task automatic rnd_step(bit s);
    step(($urandom % 10) != 0, ($urandom % 8) != 0, pick_data(), s);
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17C0DE));
    repeat (3) @(negedge clk);
    // R1 reset values
    check(vid_word == 10'h200, "R1 reset vid_word", vid_word, 10'h200);
    check(line_num == 10'd0, "R1 reset line_num", line_num, 0);
    check(field_id == 1'b0, "R1 reset field_id", field_id, 0);
    word_en = 1'b1;
    #1;
    check(smp_ready == 1'b0, "R1 reset smp_ready", smp_ready, 0);
    word_en = 1'b0;
    @(negedge clk);
    check(vid_word == 10'h200, "R1 reset hold", vid_word, 10'h200);
    rst_n = 1'b1;
    @(negedge clk);
    // directed: one full line with no enable gaps, first word is line 1 EAV
    for (int i = 0; i < T; i++) step(1'b1, 1'b1, 10'h3FF, 1'b0);
    // directed: idle cycles must hold (R2)
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 10'h155, 1'b0);
    // frame of 625 lines; select flips mid-frame and must be ignored (R12)
    while (!(m_line == 1 && m_pos == 0)) rnd_step(m_line >= 100);
    // frame of 525 lines; select drops mid-frame (R12)
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 10'h000, 1'b1);
    step(1'b1, 1'b1, 10'h200, 1'b1);
    while (!(m_line == 1 && m_pos == 0)) rnd_step(m_line < 300);
    // start of a 625-line frame again
    step(1'b1, 1'b1, 10'h200, 1'b0);
    while (m_line < 30) rnd_step(1'b1);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule